// File: doc/BRIEF.md
# Sectored Flag Status Bus Multiplexer

This block shows per-queue almost-full and almost-empty status for sixteen queues on two narrow status buses. Each bus is eight bits wide, so it carries only half of the queues at a time. The half being shown is called a sector. Sector 0 holds queues 1 to 8 and sector 1 holds queues 9 to 16. The almost-full bus runs on the write clock. The almost-empty bus runs on the read clock. Each bus has its own registered sector indicator, so a consumer always knows which half it is looking at.

One mode input selects the behaviour of both buses together:
- **Polled mode:** each bus steps to the other sector on every rising edge of its own clock.
- **Direct mode:** each bus shows the sector named by its own select input. The write-side select drives the almost-full bus and the read-side select drives the almost-empty bus, and the two choices are independent.

A queue-count input says how many queues are configured. Bus bits that belong to queues beyond that count are forced to zero. The per-queue flags arrive already computed and already synchronized to each clock.

Each bus lane is a two-state machine. The state is the sector that polled mode will show next, SECT_LO (sector 0) or SECT_HI (sector 1), and reset puts it in SECT_LO. On every edge the lane picks the sector to show: the state in polled mode, or the select input in direct mode. The transitions are:
- **SECT_LO to SECT_HI:** taken on any edge that shows sector 0.
- **SECT_HI to SECT_LO:** taken on any edge that shows sector 1.

Because the next state is always the opposite of the sector just shown, polling after a spell of direct mode carries on alternating from the last sector displayed.

Top module: `sector_flag_mux`

## Requirements
- R1: While its reset is low, a lane drives its bus to 0 and its sector indicator to 0. The first edge after reset in polled mode shows sector 0.
- R2: In polled mode, each rising edge of a lane's clock shows the sector opposite to the one shown at the previous edge. Sector indicator 0 means queues 1 to 8, which are status bits 7:0. Sector indicator 1 means queues 9 to 16, which are status bits 15:8. Bus bit b equals status bit (8*sector + b).
- R3: In direct mode, the sector shown after an edge equals the select input sampled at that edge. The write select steers the almost-full bus and the read select steers the almost-empty bus.
- R4: A single mode input governs both lanes, while the two direct selects act independently of each other.
- R5: A bus bit whose queue index (8*sector + b, counted from 0) is not below the queue count reads 0. A count of 0 blanks every bit, and counts of 16 or more leave every bit live.
- R6: The almost-full bus and its indicator change only on write-clock edges. The almost-empty bus and its indicator change only on read-clock edges.
- R7: The bus and the indicator are registered. They reflect the status, count, mode and select sampled at the most recent edge of their own clock.
- R8: When the mode returns from direct to polled, the first polled edge shows the sector opposite to the last one shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, updates the almost-full bus |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write lane |
| rd_clk | input | 1 | Read clock, updates the almost-empty bus |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read lane |
| poll_mode | input | 1 | 1 = polled sectors, 0 = direct selection (both lanes) |
| wr_sect_sel | input | 1 | Direct-mode sector for the almost-full bus |
| rd_sect_sel | input | 1 | Direct-mode sector for the almost-empty bus |
| af_status | input | 16 | Per-queue almost-full flags, bit i = queue i+1 |
| ae_status | input | 16 | Per-queue almost-empty flags, bit i = queue i+1 |
| queue_count | input | 5 | Number of configured queues |
| af_bus | output | 8 | Almost-full status of the shown sector |
| af_sector | output | 1 | Sector currently on af_bus |
| ae_bus | output | 8 | Almost-empty status of the shown sector |
| ae_sector | output | 1 | Sector currently on ae_bus |

## Verification
The assertions assume three things about the inputs:
- The mode input, the queue count and the status vectors are stable around the edges of whichever clock samples them.
- The mode input reaches both clock domains already synchronized.
- The direct selects change only between edges of their own clock.

The stimulus keeps to these assumptions by changing every input at a single instant in each 20 ns step, well away from both clock edges. The read clock is offset from the write clock so that a check falling between the two edges can tell the lanes apart. The sweep covers every queue count from 0 to 18, plus 31, in both modes and with both select values. It ends with a pseudo-random phase that toggles mode and selects freely, then a reset taken in the middle of traffic.

// File: rtl/sector_flag_pkg.sv
package sector_flag_pkg;

    localparam int SECTORS = 2;

    typedef enum logic {
        SECT_LO = 1'b0,
        SECT_HI = 1'b1
    } sector_e;

    // number of live bus bits in a sector for a given queue count
    function automatic int live_bits(input logic sec, input int count, input int bw);
        int rem;
        rem = count - (sec ? bw : 0);
        if (rem < 0) rem = 0;
        if (rem > bw) rem = bw;
        return rem;
    endfunction

endpackage

// File: rtl/sector_valid_mask.sv
module sector_valid_mask #(
    parameter int BUS_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             sect_i,
    input  logic [CNT_W-1:0] qcount_i,
    output logic [BUS_W-1:0] mask_o
);
    logic [31:0] base;

    always_comb begin
        base = sect_i ? 32'(BUS_W) : 32'd0;
    end

    for (genvar g = 0; g < BUS_W; g++) begin : g_bit
        assign mask_o[g] = (base + 32'(g)) < 32'(qcount_i);
    end
endmodule

// File: rtl/sector_lane.sv
module sector_lane
    import sector_flag_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int CNT_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     poll_i,
    input  logic                     sel_i,
    input  logic [SECTORS*BUS_W-1:0] status_i,
    input  logic [CNT_W-1:0]         qcount_i,
    output logic [BUS_W-1:0]         bus_o,
    output logic                     sec_o
);
    localparam int NUM_Q = SECTORS * BUS_W;

    sector_e          state_q, state_d, shown;
    logic [BUS_W-1:0] slice, mask;
    logic [BUS_W-1:0] bus_q;
    logic             sec_q;
    logic             started_q;

    // next-state and shown-sector decode
    always_comb begin
        shown   = poll_i ? state_q : sector_e'(sel_i);
        slice   = '0;
        state_d = SECT_LO;
        unique case (shown)
            SECT_LO: begin
                slice   = status_i[BUS_W-1:0];
                state_d = SECT_HI;
            end
            SECT_HI: begin
                slice   = status_i[NUM_Q-1:BUS_W];
                state_d = SECT_LO;
            end
        endcase
    end

    sector_valid_mask #(
        .BUS_W (BUS_W),
        .CNT_W (CNT_W)
    ) mask_i (
        .sect_i   (shown),
        .qcount_i (qcount_i),
        .mask_o   (mask)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SECT_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q     <= '0;
            sec_q     <= 1'b0;
            started_q <= 1'b0;
        end else begin
            bus_q     <= slice & mask;
            sec_q     <= shown;
            started_q <= 1'b1;
        end
    end

    assign bus_o = bus_q;
    assign sec_o = sec_q;

    // R2: polled edges alternate the displayed sector
    a_r2_polled_alternates : assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && poll_i) |=> (sec_o != $past(sec_o)));

    // R3: direct edges show the selected sector
    a_r3_direct_follows_select : assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_i) |=> (sec_o == $past(sel_i)));

    // R5: bits above the configured queue count stay low
    a_r5_unconfigured_zero : assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bus_o >> live_bits(sec_o, 32'($past(qcount_i)), BUS_W)) == '0));

    // R7: every set bus bit comes from the sampled status of the shown sector
    a_r7_bus_from_status : assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bus_o & ~BUS_W'($past(status_i) >> (BUS_W * 32'(sec_o)))) == '0));
endmodule

// File: rtl/sector_flag_mux.sv
module sector_flag_mux
    import sector_flag_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int NUM_Q = SECTORS * BUS_W,
    parameter int CNT_W = $clog2(NUM_Q + 1)
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             poll_mode,
    input  logic             wr_sect_sel,
    input  logic             rd_sect_sel,
    input  logic [NUM_Q-1:0] af_status,
    input  logic [NUM_Q-1:0] ae_status,
    input  logic [CNT_W-1:0] queue_count,
    output logic [BUS_W-1:0] af_bus,
    output logic             af_sector,
    output logic [BUS_W-1:0] ae_bus,
    output logic             ae_sector
);
    sector_lane #(
        .BUS_W (BUS_W),
        .CNT_W (CNT_W)
    ) af_lane_i (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .poll_i   (poll_mode),
        .sel_i    (wr_sect_sel),
        .status_i (af_status),
        .qcount_i (queue_count),
        .bus_o    (af_bus),
        .sec_o    (af_sector)
    );

    sector_lane #(
        .BUS_W (BUS_W),
        .CNT_W (CNT_W)
    ) ae_lane_i (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .poll_i   (poll_mode),
        .sel_i    (rd_sect_sel),
        .status_i (ae_status),
        .qcount_i (queue_count),
        .bus_o    (ae_bus),
        .sec_o    (ae_sector)
    );
endmodule

// File: tb/sector_flag_mux_tb.sv
module sector_flag_mux_tb_top;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        poll_mode = 1'b1;
    logic        wr_sect_sel = 1'b0;
    logic        rd_sect_sel = 1'b0;
    logic [15:0] af_status = '0;
    logic [15:0] ae_status = '0;
    logic [4:0]  queue_count = 5'd16;
    logic [7:0]  af_bus, ae_bus;
    logic        af_sector, ae_sector;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // expected model
    logic       nx_w = 0, nx_r = 0;
    logic [7:0] e_afb = '0, e_aeb = '0;
    logic       e_afs = 0, e_aes = 0;
    bit         prev_direct = 0;

    sector_flag_mux dut_i (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .rd_clk      (rd_clk),
        .rd_rst_n    (rd_rst_n),
        .poll_mode   (poll_mode),
        .wr_sect_sel (wr_sect_sel),
        .rd_sect_sel (rd_sect_sel),
        .af_status   (af_status),
        .ae_status   (ae_status),
        .queue_count (queue_count),
        .af_bus      (af_bus),
        .af_sector   (af_sector),
        .ae_bus      (ae_bus),
        .ae_sector   (ae_sector)
    );

    // 50 MHz; write rises at 10+20k, read at 17+20k
    initial forever #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    function automatic logic [7:0] exp_bus(input logic [15:0] st, input logic sec, input int cnt);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            int q;
            q = (sec ? 8 : 0) + b;
            r[b] = st[q] && (q < cnt);
        end
        return r;
    endfunction

    function automatic logic [15:0] pat(input int p, input int c);
        case (p)
            0:       return 16'hFFFF;
            1:       return 16'hA5C3 ^ 16'(c);
            default: return 16'h3C96 + 16'(c * 257);
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // inputs are set at 20k+2; write edge at +8, read edge at +15
    task automatic step(input string stag, input string btag, input bit mid);
        logic [7:0] o_aeb;
        logic       o_aes, sw, sr;
        o_aeb = e_aeb;
        o_aes = e_aes;
        if (!wr_rst_n) begin
            nx_w = 0; e_afb = '0; e_afs = 0;
        end else begin
            sw = poll_mode ? nx_w : wr_sect_sel;
            e_afs = sw;
            e_afb = exp_bus(af_status, sw, int'(queue_count));
            nx_w = ~sw;
        end
        if (!rd_rst_n) begin
            nx_r = 0; e_aeb = '0; e_aes = 0;
        end else begin
            sr = poll_mode ? nx_r : rd_sect_sel;
            e_aes = sr;
            e_aeb = exp_bus(ae_status, sr, int'(queue_count));
            nx_r = ~sr;
        end
        if (mid) begin
            #10;
            chk("R7", "af_bus after write edge", int'(af_bus), int'(e_afb));
            chk("R6", "ae_bus before read edge", int'(ae_bus), int'(o_aeb));
            chk("R6", "ae_sector before read edge", int'(ae_sector), int'(o_aes));
            #7;
        end else begin
            #17;
        end
        chk(stag, "af_sector", int'(af_sector), int'(e_afs));
        chk(stag, "ae_sector", int'(ae_sector), int'(e_aes));
        chk(btag, "af_bus", int'(af_bus), int'(e_afb));
        chk(btag, "ae_bus", int'(ae_bus), int'(e_aeb));
        #3;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        int cl[8];
        lf = 32'h1BADF00D;
        cl = '{0, 3, 5, 8, 9, 13, 16, 31};
        #2;
        // R1: reset state
        step("R1", "R1", 0);
        step("R1", "R1", 0);
        wr_rst_n = 1; rd_rst_n = 1;
        af_status = 16'h00FF; ae_status = 16'hFF00;
        step("R1", "R2", 0);
        step("R2", "R2", 0);

        // polled sweep over counts and patterns
        poll_mode = 1;
        for (int c = 0; c <= 19; c++) begin
            for (int p = 0; p < 3; p++) begin
                queue_count = (c == 19) ? 5'd31 : 5'(c);
                af_status = pat(p, c);
                ae_status = ~pat(p, c + 1);
                for (int k = 0; k < 4; k++)
                    step("R2", (c < 16) ? "R5" : "R2", 0);
            end
        end

        // direct sweep: independent selects, one shared mode
        poll_mode = 0;
        for (int i = 0; i < 8; i++) begin
            for (int ws = 0; ws < 2; ws++) begin
                for (int rs = 0; rs < 2; rs++) begin
                    for (int p = 0; p < 3; p++) begin
                        queue_count = 5'(cl[i]);
                        wr_sect_sel = ws[0];
                        rd_sect_sel = rs[0];
                        af_status = pat(p, cl[i]);
                        ae_status = pat(2 - p, cl[i] + 7);
                        step((ws != rs) ? "R4" : "R3", "R5", 0);
                    end
                end
            end
        end
        prev_direct = 1;

        // pseudo-random mixing with mid-step checks
        for (int n = 0; n < 600; n++) begin
            string st;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            poll_mode = lf[0] | lf[1];
            wr_sect_sel = lf[2];
            rd_sect_sel = lf[3];
            queue_count = (lf[8:4] > 5'd20) ? 5'd16 : lf[8:4];
            af_status = lf[24:9];
            ae_status = lf[31:16] ^ lf[15:0];
            st = (poll_mode && prev_direct) ? "R8" : (poll_mode ? "R2" : "R3");
            step(st, "R7", 1);
            prev_direct = !poll_mode;
        end

        // reset mid-traffic, then polled restarts at sector 0
        poll_mode = 1;
        queue_count = 5'd16;
        wr_rst_n = 0; rd_rst_n = 0;
        step("R1", "R1", 0);
        wr_rst_n = 1; rd_rst_n = 1;
        step("R1", "R2", 0);
        step("R2", "R2", 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule